// File: doc/BRIEF.md
# Per-Core Clock Ratio Unit with Staged Reload

This block produces one clock-enable strobe per processor core, each at a programmable fraction (1:1, 1:2 or 1:3) of the input clock. Software uses a small register bus. It writes a 6-bit ratio code for each core into a value register. The code is held there and is not used yet.

To apply new codes, software writes the control register. It marks the cores to reload and raises a global trigger bit in the same write or in a later one. Every marked core latches its staged code and keeps its present ratio until its current divide period ends. It then switches, so no strobe is cut short or doubled. A busy flag in the control register stays high until every marked core has switched. Software then clears the trigger and select bits.

Each core runs a two-state machine. RUN is the normal counting state. RUN goes to ARMED on a reload request (transition ARM). ARMED goes back to RUN at the end of the current period, when the new ratio is adopted (transition SWITCH). A fresh request while ARMED stays in ARMED and re-latches the code (transition REARM).

Top module: `core_clk_ratio_unit`

## Requirements
- R1: After reset the control register reads 0x00000000 and the value register reads 0x01010101. Every core strobe is high on every cycle, because each core runs at ratio 1.
- R2: The control register is at address 0x0 and the value register is at address 0xC. The code for core n sits at value bits [8n+5:8n]. Written codes read back unchanged. Value bits outside those fields read 0, and any other address reads 0.
- R3: A core at active ratio r (1, 2 or 3) raises its strobe on exactly one cycle in every r cycles. Any six consecutive cycles therefore contain 6/r strobes.
- R4: Writing the value register alone does not change any core's strobe rate.
- R5: A write to address 0x0 that sets bit 24 while the stored bit 24 is 0 is a trigger. Every core n whose bit 20+n is 1 in that write adopts its staged code. Every other core keeps its ratio.
- R6: A write that keeps bit 24 set while it is already 1 causes no reload. A reload is accepted again only after bit 24 has been written 0 and then 1.
- R7: A selected core switches only at the end of its current period. Every gap between strobes is either the old ratio or the new one, and the switch happens within old-ratio cycles of the trigger.
- R8: A code of 0 is applied as ratio 1 and a code above 3 is applied as ratio 3. The stored code still reads back as written.
- R9: Control bit 31 is a read-only busy flag. It is 1 from the trigger write until every selected core has switched. Writes to bit 31 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core_ce | output | 4 | Clock-enable strobe, one bit per core |

## Verification
Read data follows the address in the same cycle, so the bench samples it 1 ns after driving the address on a falling edge. A register write takes effect at the rising edge that follows the write strobe, so the busy flag is visible from the next falling edge. From there the bench polls busy once per cycle and expects it to drop after one to old-ratio cycles. Strobe rates are checked only once the switch is complete, by counting strobes over six consecutive falling-edge samples; this count does not depend on phase. A monitor checks every gap between strobes against the ratios allowed at that time.

// File: rtl/crt_pkg.sv
package crt_pkg;
    typedef enum logic [0:0] {
        CS_RUN   = 1'b0,
        CS_ARMED = 1'b1
    } core_state_e;
endpackage

// File: rtl/crt_regfile.sv
module crt_regfile #(
    parameter int NUM_CORES  = 4,
    parameter int DIV_W      = 6,
    parameter int LANE_W     = 8,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int RELOAD_LSB = 20,
    parameter int TRIG_BIT   = 24,
    parameter int BUSY_BIT   = 31,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h0,
    parameter logic [ADDR_W-1:0] VAL_ADDR  = 4'hC
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic                       busy_i,
    output logic [NUM_CORES*DIV_W-1:0] field_o,
    output logic [NUM_CORES-1:0]       load_o
);
    logic [NUM_CORES-1:0] sel_q;
    logic                 trig_q;
    logic [DIV_W-1:0]     fld_q [NUM_CORES];
    logic                 wr_ctrl;
    logic                 wr_val;
    logic                 trig_fire;

    assign wr_ctrl   = bus_wr && (bus_addr == CTRL_ADDR);
    assign wr_val    = bus_wr && (bus_addr == VAL_ADDR);
    assign trig_fire = wr_ctrl && bus_wdata[TRIG_BIT] && !trig_q;
    assign load_o    = trig_fire ? bus_wdata[RELOAD_LSB +: NUM_CORES] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            trig_q <= 1'b0;
        end else if (wr_ctrl) begin
            sel_q  <= bus_wdata[RELOAD_LSB +: NUM_CORES];
            trig_q <= bus_wdata[TRIG_BIT];
        end
    end

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                fld_q[g] <= DIV_W'(1);
            else if (wr_val)
                fld_q[g] <= bus_wdata[g*LANE_W +: DIV_W];
        end
        assign field_o[g*DIV_W +: DIV_W] = fld_q[g];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata[RELOAD_LSB +: NUM_CORES] = sel_q;
            bus_rdata[TRIG_BIT]                = trig_q;
            bus_rdata[BUSY_BIT]                = busy_i;
        end else if (bus_addr == VAL_ADDR) begin
            for (int i = 0; i < NUM_CORES; i++)
                bus_rdata[i*LANE_W +: DIV_W] = fld_q[i];
        end
    end

    AST_LOAD_LEAVES_TRIG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|load_o) |=> trig_q); // R5
    AST_HELD_TRIG_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q && $past(trig_q)) |-> (load_o == '0)); // R6
endmodule

// File: rtl/crt_core_gen.sv
module crt_core_gen
    import crt_pkg::*;
#(
    parameter int DIV_W     = 6,
    parameter int MAX_RATIO = 3,
    localparam int CNT_W    = $clog2(MAX_RATIO + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] field_i,
    output logic             ce_o,
    output logic             armed_o
);
    core_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] pend_q;
    logic [CNT_W-1:0] req_ratio;
    logic             period_end;

    always_comb begin
        if (field_i == '0)
            req_ratio = CNT_W'(1);
        else if (field_i > DIV_W'(MAX_RATIO))
            req_ratio = CNT_W'(MAX_RATIO);
        else
            req_ratio = field_i[CNT_W-1:0];
    end

    assign period_end = (cnt_q == act_q - CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_RUN:   if (load_i) state_d = CS_ARMED;
            CS_ARMED: if (!load_i && period_end) state_d = CS_RUN;
            default:  state_d = CS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            act_q  <= CNT_W'(1);
            pend_q <= CNT_W'(1);
        end else begin
            if (load_i)
                pend_q <= req_ratio;
            if (period_end) begin
                cnt_q <= '0;
                if (state_q == CS_ARMED && !load_i)
                    act_q <= pend_q;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    always_comb begin
        ce_o    = period_end;
        armed_o = (state_q == CS_ARMED);
    end

    AST_CNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < act_q); // R3
    AST_RATIO_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q >= CNT_W'(1)) && (act_q <= CNT_W'(MAX_RATIO))); // R8
    AST_SWITCH_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != $past(act_q)) |-> $past(ce_o)); // R7
    AST_ARMED_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_ARMED && $past(state_q) == CS_RUN) |-> $past(load_i)); // R5
endmodule

// File: rtl/core_clk_ratio_unit.sv
module core_clk_ratio_unit #(
    parameter int NUM_CORES  = 4,
    parameter int DIV_W      = 6,
    parameter int MAX_RATIO  = 3,
    parameter int LANE_W     = 8,
    parameter int RELOAD_LSB = 20,
    parameter int TRIG_BIT   = 24,
    parameter int BUSY_BIT   = 31,
    localparam int DATA_W    = NUM_CORES * LANE_W,
    localparam int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CORES-1:0] core_ce
);
    logic [NUM_CORES*DIV_W-1:0] fields;
    logic [NUM_CORES-1:0]       loads;
    logic [NUM_CORES-1:0]       armed;
    logic                       busy;

    assign busy = |armed;

    crt_regfile #(
        .NUM_CORES (NUM_CORES),
        .DIV_W     (DIV_W),
        .LANE_W    (LANE_W),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .RELOAD_LSB(RELOAD_LSB),
        .TRIG_BIT  (TRIG_BIT),
        .BUSY_BIT  (BUSY_BIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .busy_i   (busy),
        .field_o  (fields),
        .load_o   (loads)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        crt_core_gen #(
            .DIV_W    (DIV_W),
            .MAX_RATIO(MAX_RATIO)
        ) u_gen (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (loads[c]),
            .field_i(fields[c*DIV_W +: DIV_W]),
            .ce_o   (core_ce[c]),
            .armed_o(armed[c])
        );
    end

    AST_BUSY_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(|loads)); // R9
endmodule

// File: tb/core_clk_ratio_unit_test.sv
`timescale 1ns/1ps
module core_clk_ratio_unit_test;
    localparam int NC = 4;
    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_VAL  = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NC-1:0] core_ce;

    int checks = 0;
    int fails = 0;
    int ratio [NC];
    int vals [NC];
    int lo [NC];
    int hi [NC];
    int pc [NC];
    int last [NC];
    bit seen [NC];
    bit mon_en = 1'b0;
    int cyc = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    core_clk_ratio_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_ce(core_ce)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int clampf(input int v);
        if (v == 0) return 1;
        if (v > 3) return 3;
        return v;
    endfunction

    function automatic logic [31:0] pack();
        logic [31:0] w = '0;
        for (int i = 0; i < NC; i++) w[i*8 +: 8] = 8'(vals[i] & 63);
        return w;
    endfunction

    // R7: every strobe gap must match an allowed ratio
    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            for (int i = 0; i < NC; i++) begin
                if (core_ce[i]) begin
                    if (seen[i])
                        chk((cyc - last[i]) == lo[i] || (cyc - last[i]) == hi[i],
                            "R7 gap", 32'(cyc - last[i]), 32'(hi[i]));
                    seen[i] = 1'b1;
                    last[i] = cyc;
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a);
        bus_addr = a;
        #1 rd = bus_rdata;
    endtask

    task automatic count6();
        for (int i = 0; i < NC; i++) pc[i] = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            for (int i = 0; i < NC; i++) if (core_ce[i]) pc[i]++;
        end
    endtask

    task automatic check_rates(input string req);
        count6();
        for (int i = 0; i < NC; i++)
            chk(pc[i] == 6 / ratio[i], req, 32'(pc[i]), 32'(6 / ratio[i]));
    endtask

    task automatic reload(input logic [NC-1:0] mask);
        int oldmax = 1;
        int bc = 0;
        for (int i = 0; i < NC; i++) if (mask[i]) begin
            lo[i] = ratio[i]; hi[i] = clampf(vals[i]);
            if (ratio[i] > oldmax) oldmax = ratio[i];
        end
        wr(A_CTRL, (32'(mask) << 20) | (32'd1 << 24));
        peek(A_CTRL);
        while (rd[31] && bc < 10) begin
            bc++;
            @(negedge clk);
            peek(A_CTRL);
        end
        chk(bc >= 1 && bc <= oldmax, "R9 busy window", 32'(bc), 32'(oldmax));
        for (int i = 0; i < NC; i++) if (mask[i]) ratio[i] = clampf(vals[i]);
        check_rates("R5 R8 R3 new rates");
        for (int i = 0; i < NC; i++) begin lo[i] = ratio[i]; hi[i] = ratio[i]; end
        wr(A_CTRL, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < NC; i++) begin
            ratio[i] = 1; vals[i] = 1; lo[i] = 1; hi[i] = 1; seen[i] = 1'b0; last[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        peek(A_CTRL);
        chk(rd == 32'h0, "R1 ctrl reset", rd, 32'h0);
        peek(A_VAL);
        chk(rd == 32'h01010101, "R1 value reset", rd, 32'h01010101);
        chk(core_ce == 4'hF, "R1 strobes", 32'(core_ce), 32'hF);
        mon_en = 1'b1;
        check_rates("R1 R3 ratio 1");

        // R2 map, masking and unmapped address
        peek(4'h4);
        chk(rd == 32'h0, "R2 unmapped", rd, 32'h0);
        wr(A_VAL, 32'hFFFFFFFF);
        peek(A_VAL);
        chk(rd == 32'h3F3F3F3F, "R2 field mask", rd, 32'h3F3F3F3F);
        check_rates("R4 value write alone");
        wr(A_VAL, 32'h01010101);

        // sweep each core through codes
        for (int c = 0; c < NC; c++) begin
            int codes [8] = '{2, 3, 0, 5, 63, 1, 3, 1};
            for (int k = 0; k < 8; k++) begin
                vals[c] = codes[k];
                wr(A_VAL, pack());
                peek(A_VAL);
                chk(rd == pack(), "R2 R8 readback", rd, pack());
                check_rates("R4 staged only");
                reload(4'(1 << c));
            end
        end

        // R6 held trigger
        vals[1] = 2; wr(A_VAL, pack());
        lo[1] = 1; hi[1] = 2;
        wr(A_CTRL, (32'd2 << 20) | (32'd1 << 24));
        repeat (4) @(negedge clk);
        ratio[1] = 2; lo[1] = 2;
        vals[1] = 3; wr(A_VAL, pack());
        wr(A_CTRL, (32'd2 << 20) | (32'd1 << 24));
        peek(A_CTRL);
        chk(rd[31] == 1'b0, "R6 no busy on held trigger", 32'(rd[31]), 32'h0);
        check_rates("R6 held trigger no reload");
        wr(A_CTRL, 32'd0);
        reload(4'b0010);
        chk(ratio[1] == 3, "R6 re-armed trigger", 32'(ratio[1]), 32'd3);

        // multi-core reload, R5 others unchanged
        vals[0] = 3; vals[1] = 1; vals[2] = 2; vals[3] = 0;
        wr(A_VAL, pack());
        reload(4'b0101);

        // R9 busy bit not writable
        wr(A_CTRL, 32'h80000000);
        peek(A_CTRL);
        chk(rd == 32'h0, "R9 busy read-only", rd, 32'h0);
        check_rates("R9 R3 rates after bit31 write");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(1_000_000);
        checks++; fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule